// File: doc/BRIEF.md
# MDIO Management Controller

This block runs management-bus read and write transactions (Clause 22 frame format) towards external PHY devices on behalf of software. Software programs a control word with an enable bit and a clock divider, then writes a packed access word that carries the command: a go/busy flag, the direction, the PHY address, the PHY register address and, for writes, the data. The controller derives the management clock from the system clock, shifts the frame out on the data pin, releases the pin for the reply on reads, and captures the 16 returned bits.

The busy flag clears by itself when the frame is complete. After a read, the access word holds the captured data in its low half. A presence bitmask records every PHY address that has driven the turnaround low during a read, so software can find out which addresses are populated. While busy is set, the access word ignores writes. Clearing the enable bit stops all pin activity and cancels any frame in flight.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the control word (select 0) reads 0x8000_0000, and both the access word (select 1) and the presence mask (select 2) read 0.
- R2: In the access word, bit 31 is busy/go, bit 30 selects write (1) or read (0), bits 25:21 hold the register address, bits 20:16 the PHY address and bits 15:0 the data. A write of this word with bit 31 set, while the block is enabled and idle, starts a frame, and bit 31 then reads 1 until the frame ends.
- R3: While busy reads 1, a write to the access word changes neither the frame on the pins nor any field of the word.
- R4: A frame is 64 MDC periods, sent most significant bit first: 32 ones, then 01, then the opcode (10 for read, 01 for write), 5 PHY address bits, 5 register address bits, a turnaround (10 on writes), and 16 data bits.
- R5: On a read, the output enable is low for the two turnaround bits and the 16 data bits. Input data is taken at each rising MDC edge. When the frame ends, busy clears and bits 15:0 hold the captured data, first bit received in bit 15.
- R6: A read sets bit n of the presence mask (n = PHY address) when the second turnaround bit is sampled low. The bit is not set when that turnaround bit is high. Set bits stay set until reset.
- R7: The MDC period is max(div,1)+1 system clocks, where div is control bits 7:0. MDC stays low while no frame is in progress.
- R8: Control bit 30 enables the block. While it is 0, MDC and the output enable stay low and an access-word write with bit 31 set is ignored. Clearing it during a frame cancels the frame and clears busy.
- R9: Control bit 31 reads 1 exactly when no frame is busy; bit 30 and bits 7:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 2 | Register select: 0 control, 1 access, 2 presence mask |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that software changes the divider only while no frame is busy. A change of divider during a frame could leave the running period counter above the new limit. They also assume that the select input only takes the values 0 to 2. The bench writes the control word only between frames or to cancel a frame, and it keeps the divider small in random runs. It acts as the PHY: it drives the data-in pin only after a rising MDC edge, so the next rising edge samples a settled value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam int WORD_W = 32;

  // access word field positions (software-visible)
  localparam int ACC_BUSY = 31;
  localparam int ACC_WR   = 30;
  localparam int REG_LSB  = 21;
  localparam int PHY_LSB  = 16;

  // control word field positions
  localparam int CTL_IDLE = 31;
  localparam int CTL_EN   = 30;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ACCESS = 2'd1,
    SEL_ALIVE  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, div_eff;
  logic [DIV_W:0]   hi_start, cnt_inc;
  logic             mdc_q;

  // period is div_eff+1 clocks; a divider of 0 is clamped to 1
  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign hi_start = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;
  assign cnt_inc  = {1'b0, cnt_q} + (DIV_W+1)'(1);

  // strobes qualify the edge at which mdc_q changes
  assign fall_o = run_i && (cnt_q == div_eff);
  assign rise_o = run_i && (cnt_inc == hi_start);
  assign mdc_o  = mdc_q & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i || fall_o) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_inc[DIV_W-1:0];
      mdc_q <= (cnt_inc >= hi_start);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic              alive_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] ALIVE_IDX = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);

  logic                 active_q, wr_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q, img;
  logic [DATA_W-1:0]    rdata_q;

  always_comb begin
    img = {{PRE_LEN{1'b1}}, 2'b01,
           cmd_i.wr ? 2'b01 : 2'b10,
           cmd_i.phy, cmd_i.regad,
           cmd_i.wr ? 2'b10 : 2'b11,
           cmd_i.wr ? cmd_i.data : {DATA_W{1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rdata_q  <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      wr_q     <= cmd_i.wr;
      idx_q    <= '0;
      sh_q     <= img;
    end else if (active_q) begin
      if (rise_i && !wr_q && idx_q >= DATA_IDX)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        sh_q  <= sh_q << 1;
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == LAST_IDX) active_q <= 1'b0;
      end
    end
  end

  assign active_o  = active_q;
  assign mdio_o    = active_q && sh_q[FRAME_LEN-1];
  assign mdio_oe_o = active_q && (wr_q || idx_q < TA_IDX);
  assign done_o    = active_q && fall_i && (idx_q == LAST_IDX);
  assign alive_o   = active_q && rise_i && !wr_q && (idx_q == ALIVE_IDX) && !mdio_i;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_sel_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int ALIVE_W = 1 << PHY_AW;

  logic               en_q, busy_q;
  logic [DIV_W-1:0]   div_q;
  mdio_cmd_t          cmd_q, acc_cmd;
  logic [ALIVE_W-1:0] alive_q;

  logic wr_ctrl, wr_acc, start, active, done, alive_hit, rise, fall;
  logic [DATA_W-1:0] rdata;
  logic unused_wdata;

  assign wr_ctrl = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
  assign wr_acc  = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_ACCESS);
  assign unused_wdata = ^reg_wdata_i;

  assign acc_cmd.wr    = reg_wdata_i[ACC_WR];
  assign acc_cmd.phy   = reg_wdata_i[PHY_LSB +: PHY_AW];
  assign acc_cmd.regad = reg_wdata_i[REG_LSB +: REG_AW];
  assign acc_cmd.data  = reg_wdata_i[DATA_W-1:0];

  assign start = wr_acc && !busy_q && en_q && reg_wdata_i[ACC_BUSY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      div_q   <= '0;
      busy_q  <= 1'b0;
      cmd_q   <= '0;
      alive_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[CTL_EN];
        div_q <= reg_wdata_i[DIV_W-1:0];
      end
      if (!en_q) begin
        busy_q <= 1'b0;
      end else if (done) begin
        busy_q <= 1'b0;
        if (!cmd_q.wr) cmd_q.data <= rdata;
      end else if (start) begin
        busy_q <= 1'b1;
      end
      // a go request while disabled is dropped whole
      if (wr_acc && !busy_q && !(reg_wdata_i[ACC_BUSY] && !en_q))
        cmd_q <= acc_cmd;
      if (alive_hit) alive_q[cmd_q.phy] <= 1'b1;
    end
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .start_i   (start),
    .cmd_i     (acc_cmd),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .alive_o   (alive_hit),
    .rdata_o   (rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_e'(reg_sel_i))
      SEL_CTRL: begin
        reg_rdata_o[CTL_IDLE]    = !busy_q;
        reg_rdata_o[CTL_EN]      = en_q;
        reg_rdata_o[DIV_W-1:0]   = div_q;
      end
      SEL_ACCESS: begin
        reg_rdata_o[ACC_BUSY]            = busy_q;
        reg_rdata_o[ACC_WR]              = cmd_q.wr;
        reg_rdata_o[REG_LSB +: REG_AW]   = cmd_q.regad;
        reg_rdata_o[PHY_LSB +: PHY_AW]   = cmd_q.phy;
        reg_rdata_o[DATA_W-1:0]          = cmd_q.data;
      end
      SEL_ALIVE: reg_rdata_o = alive_q;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_sel_i,
  input logic        mdc_o,
  input logic        mdio_oe_o,
  input logic        busy_i,
  input logic        en_i,
  input logic        wr_i,
  input logic [4:0]  phy_i,
  input logic [4:0]  regad_i,
  input logic [31:0] alive_i
);
  // R2: a frame only starts while enabled
  p_start_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(en_i));

  // R3: command fields hold across a write made while busy
  p_busy_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_i && reg_sel_i == 2'd1) |=>
      ($stable(phy_i) && $stable(regad_i) && $stable(wr_i)));

  // R7: pins quiet when nothing is busy
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_o && !mdio_oe_o));

  // R8: pins quiet once disabled for a cycle
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!mdc_o && !mdio_oe_o));

  // R6: presence bits are sticky
  p_alive_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alive_i & $past(alive_i)) == $past(alive_i)));
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_sel_i (reg_sel_i),
  .mdc_o     (mdc_o),
  .mdio_oe_o (mdio_oe_o),
  .busy_i    (busy_q),
  .en_i      (en_q),
  .wr_i      (cmd_q.wr),
  .phy_i     (cmd_q.phy),
  .regad_i   (cmd_q.regad),
  .alive_i   (alive_q)
);

// File: tb/tb_mdio_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] alive_exp = '0;

  always #5 clk = ~clk;

  mdio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b0;
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    reg_wdata = v;
    reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [63:0] frame_img(bit w, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] acc_word(bit go, bit w, logic [4:0] phy,
                                           logic [4:0] rg, logic [15:0] d);
    return {go, w, 4'b0000, rg, phy, d};
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(2'd1, v);
      if (!v[31]) return;
    end
  endtask

  // acts as the PHY; returns the measured MDC period in clocks
  task automatic run_txn(input bit w, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input bit respond, input logic [15:0] resp,
                         input bit inject, output int period);
    logic [63:0] img, got, got_oe, miso, exp_oe;
    logic [31:0] v;
    realtime t0;
    img = frame_img(w, phy, rg, d);
    miso = '1;
    if (!w) begin
      miso[63-47] = !respond;
      miso[15:0] = resp;
    end
    exp_oe = w ? '1 : {{46{1'b1}}, 18'b0};
    mdio_in = 1'b1;
    period = 0;
    t0 = 0;
    wr(2'd1, acc_word(1'b1, w, phy, rg, d));
    if (inject) wr(2'd1, acc_word(1'b1, !w, ~phy, ~rg, ~d));
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc);
      #1;
      if (i == 0) t0 = $realtime;
      if (i == 1) period = int'(($realtime - t0) / 10.0);
      got[63-i] = mdio_out;
      got_oe[63-i] = mdio_oe;
      if (i < 63) mdio_in = miso[63-(i+1)];
    end
    wait_idle();
    check(got_oe == exp_oe, w ? "R4" : "R5", "output enable per bit", got_oe, exp_oe);
    check((got & exp_oe) == (img & exp_oe), "R4", "frame bits", got & exp_oe, img & exp_oe);
    rd(2'd1, v);
    check(v == acc_word(1'b0, w, phy, rg, w ? d : resp), w ? "R2" : "R5",
          "access word after frame", {32'b0, v}, {32'b0, acc_word(1'b0, w, phy, rg, w ? d : resp)});
    if (!w && respond) alive_exp[phy] = 1'b1;
    rd(2'd2, v);
    check(v == alive_exp, "R6", "presence mask", {32'b0, v}, {32'b0, alive_exp});
    check(mdc == 1'b0, "R7", "mdc low when idle", {63'b0, mdc}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int per;
    bit quiet;
    int unsigned seed;
    seed = $urandom(32'd20251);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 32'h8000_0000, "R1", "control after reset", {32'b0, v}, 64'h8000_0000);
    rd(2'd1, v); check(v == 32'h0, "R1", "access after reset", {32'b0, v}, 64'h0);
    rd(2'd2, v); check(v == 32'h0, "R1", "mask after reset", {32'b0, v}, 64'h0);

    // R8 disabled: go write ignored, pins quiet
    wr(2'd1, acc_word(1'b1, 1'b1, 5'd4, 5'd9, 16'hBEEF));
    rd(2'd1, v); check(v == 32'h0, "R8", "go ignored while disabled", {32'b0, v}, 64'h0);
    quiet = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mdc || mdio_oe) quiet = 0;
    end
    check(quiet, "R8", "pins quiet while disabled", {63'b0, quiet}, 64'd1);

    // R9 enable and divider readback
    wr(2'd0, 32'h4000_0003);
    rd(2'd0, v); check(v == 32'hC000_0003, "R9", "control readback", {32'b0, v}, 64'hC000_0003);

    // directed frames
    run_txn(1'b1, 5'd5, 5'h11, 16'hA5C3, 1'b0, 16'h0, 1'b0, per);
    check(per == 4, "R7", "period div=3", per, 4);
    run_txn(1'b0, 5'd1, 5'd2, 16'h0, 1'b1, 16'h1234, 1'b0, per);
    run_txn(1'b0, 5'd7, 5'd3, 16'h0, 1'b0, 16'hFFFF, 1'b0, per);
    run_txn(1'b0, 5'd31, 5'd31, 16'h0, 1'b1, 16'h8001, 1'b0, per);

    wr(2'd0, 32'h4000_0000);
    run_txn(1'b1, 5'd0, 5'd0, 16'h0001, 1'b0, 16'h0, 1'b0, per);
    check(per == 2, "R7", "period div=0 clamps", per, 2);
    wr(2'd0, 32'h4000_0001);
    run_txn(1'b0, 5'd2, 5'd6, 16'h0, 1'b1, 16'h0F0F, 1'b0, per);
    check(per == 2, "R7", "period div=1", per, 2);

    // R3 write while busy is ignored
    wr(2'd0, 32'h4000_0009);
    run_txn(1'b1, 5'd3, 5'h0A, 16'h5AA5, 1'b0, 16'h0, 1'b1, per);
    check(per == 10, "R7", "period div=9", per, 10);
    rd(2'd1, v);
    check(v == acc_word(1'b0, 1'b1, 5'd3, 5'h0A, 16'h5AA5), "R3", "fields after busy write",
          {32'b0, v}, {32'b0, acc_word(1'b0, 1'b1, 5'd3, 5'h0A, 16'h5AA5)});

    // R8 cancel mid-frame, R9 idle flag while busy
    wr(2'd1, acc_word(1'b1, 1'b0, 5'd9, 5'd1, 16'h0));
    repeat (3) @(posedge mdc);
    rd(2'd0, v); check(v[31] == 1'b0, "R9", "idle flag while busy", {63'b0, v[31]}, 64'd0);
    rd(2'd1, v); check(v[31] == 1'b1, "R2", "busy while running", {63'b0, v[31]}, 64'd1);
    wr(2'd0, 32'h0000_0009);
    repeat (2) @(negedge clk);
    rd(2'd1, v); check(v[31] == 1'b0, "R8", "busy cleared by disable", {63'b0, v[31]}, 64'd0);
    quiet = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mdc || mdio_oe) quiet = 0;
    end
    check(quiet, "R8", "pins quiet after cancel", {63'b0, quiet}, 64'd1);

    // recovery and random frames
    for (int n = 0; n < 20; n++) begin
      logic [7:0] dv;
      bit w, resp_on;
      logic [4:0] phy, rg;
      logic [15:0] d, r;
      dv = 8'($urandom_range(0, 5));
      w = 1'($urandom);
      resp_on = 1'($urandom);
      phy = 5'($urandom);
      rg = 5'($urandom);
      d = 16'($urandom);
      r = resp_on ? 16'($urandom) : 16'hFFFF;
      wr(2'd0, {2'b01, 22'b0, dv});
      run_txn(w, phy, rg, d, resp_on, r, 1'b0, per);
      check(per == ((dv == 0) ? 2 : dv + 1), "R7", "random period", per, (dv == 0) ? 2 : dv + 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule